// File: doc/BRIEF.md
# Dual-Channel Countdown Timer with Interrupt Status

This block is a register-mapped peripheral with two independent countdown channels and a shared interrupt section. Software programs a reload value and a control word per channel. The control word starts the channel once, pauses it, or lets it run and reload forever. A rate code in the same word picks how often the channel's counter steps. The current count of each channel can be read back at any time.

Each expiry latches a raw status bit. A mask register selects which bits are visible in the masked view. The single interrupt line follows masked bit 0. Software clears status bits by writing ones to a strobe register that holds nothing. A free-running time counter gives software a monotonic timestamp.

The register port is a plain single-cycle bus. A write takes effect at the clock edge where `bus_wr` is high. Read data is combinational from `bus_addr` and reflects the state registered at the most recent edge. Reads have no side effects. The bus has no handshake and never stalls.

Top module: `dual_countdown_timer`

## Requirements
- R1: After reset, both channels are stopped with count, reload and control at 0. Mask and raw status are 0, `irq` is low, and the time counter is 0.
- R2: Writing a channel's control word with bits [1:0] = 0 copies the reload value into the count and starts a one-shot run. The count drops by 1 on each step. On a step taken while the count is 1 or 0, the channel expires, the count becomes 0, and the channel stops.
- R3: Control bits [1:0] = 2 start a periodic run from the present count, without reloading. On each expiry the count takes the reload value and the channel keeps running.
- R4: Control bits [1:0] = 1 stop the channel and freeze its count. Code 3 leaves both the run state and the count unchanged. A stopped channel's count never changes except through a control write.
- R5: Control bits [4:2] hold a rate code k. A channel steps only in cycles where the low k bits of a shared prescaler are all ones, so it steps once every 2^k clocks. The prescaler counts clocks from reset.
- R6: An expiry of channel n sets raw status bit n on the same clock edge.
- R7: Writing offset 0x44 clears the raw bits written as 1. If an expiry and a clear of the same bit fall in one cycle, the bit stays set. The register stores nothing and reads as 0.
- R8: Offset 0x4C reads raw AND mask. `irq` equals masked bit 0 and changes on the same edge as a mask write, a clear write or an expiry.
- R9: The time register at 0x30 increases by exactly 1 every clock.
- R10: Channel n sits at base 0x10·n, with the reload value at +0x0, the count at +0x4 (read-only) and the control word at +0x8. Mask is at 0x40 and raw status at 0x48 (read-only). Reload and control read back as written, with control keeping only bits [4:0]. Unmapped offsets read 0. Writes to read-only offsets have no effect.
- R11: A control write in a cycle where the channel would also step takes effect, and that step is dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for `bus_addr` |
| irq | output | 1 | Interrupt, high while masked status bit 0 is set |

## Verification
The bench runs a channel with reload 1 at the fastest rate, so that it expires on every clock. It writes clears into those expiries. A design that let the clear win would drop `irq` and lose a pending event. Every control write in that phase also lands on a step. A design that decremented after a load would read one count low. The bench starts a periodic run from count 0 and from a held count, which exposes a design that reloads before it counts down. It issues the reserved code and writes to the read-only offsets; a design that decoded these as hold, or as stores, shows a changed count or status at the next read. A slow rate code on the second channel shows whether the step period is aligned to the shared prescaler from reset.

// File: rtl/cdtimer_pkg.sv
package cdtimer_pkg;

  // Operation field of a channel control word, bits [1:0]
  typedef enum logic [1:0] {
    OP_LOAD = 2'd0,
    OP_HOLD = 2'd1,
    OP_RUN  = 2'd2,
    OP_KEEP = 2'd3
  } tmr_op_e;

  // Run state of a channel
  typedef enum logic [1:0] {
    MODE_IDLE = 2'd0,
    MODE_ONCE = 2'd1,
    MODE_LOOP = 2'd2
  } tmr_mode_e;

  // Register map (byte offsets)
  localparam int CH_STRIDE = 16;
  localparam int OFS_DIV   = 0;
  localparam int OFS_DATA  = 4;
  localparam int OFS_CTRL  = 8;
  localparam int OFS_TIME  = 48;
  localparam int OFS_MASK  = 64;
  localparam int OFS_ACK   = 68;
  localparam int OFS_RAW   = 72;
  localparam int OFS_MSKD  = 76;

endpackage

// File: rtl/cdtimer_prescale.sv
module cdtimer_prescale #(
  parameter int RATE_W = 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  output logic [(2**RATE_W)-1:0] tick_o
);
  localparam int NTAP  = 2 ** RATE_W;
  localparam int PRE_W = NTAP - 1;

  logic [PRE_W-1:0] pre_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_q + 1'b1;
  end

  // Tap k fires when the low k prescaler bits are all ones
  assign tick_o[0] = 1'b1;
  for (genvar k = 1; k < NTAP; k++) begin : g_tap
    assign tick_o[k] = &pre_q[k-1:0];
  end
endmodule

// File: rtl/cdtimer_channel.sv
module cdtimer_channel
  import cdtimer_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int RATE_W = 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   div_wr,
  input  logic                   ctrl_wr,
  input  logic [CNT_W-1:0]       div_wdata,
  input  logic [RATE_W+1:0]      ctrl_wdata,
  input  logic [(2**RATE_W)-1:0] tick_vec,
  output logic [CNT_W-1:0]       div_q,
  output logic [RATE_W+1:0]      ctrl_q,
  output logic [CNT_W-1:0]       count_q,
  output logic                   running,
  output logic                   expire
);
  tmr_mode_e        mode_q, mode_d;
  logic [CNT_W-1:0] cnt_d;
  logic             tick;
  tmr_op_e          op;

  assign op      = tmr_op_e'(ctrl_wdata[1:0]);
  assign tick    = tick_vec[ctrl_q[RATE_W+1:2]];
  assign running = (mode_q != MODE_IDLE);

  always_comb begin
    mode_d = mode_q;
    cnt_d  = count_q;
    expire = 1'b0;
    if (ctrl_wr) begin
      // a control write takes priority over a step in the same cycle
      case (op)
        OP_LOAD: begin
          cnt_d  = div_q;
          mode_d = MODE_ONCE;
        end
        OP_HOLD: mode_d = MODE_IDLE;
        OP_RUN:  mode_d = MODE_LOOP;
        default: ;
      endcase
    end else if (tick && mode_q != MODE_IDLE) begin
      if (count_q <= CNT_W'(1)) begin
        expire = 1'b1;
        if (mode_q == MODE_LOOP) begin
          cnt_d = div_q;
        end else begin
          cnt_d  = '0;
          mode_d = MODE_IDLE;
        end
      end else begin
        cnt_d = count_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q   <= '0;
      ctrl_q  <= '0;
      count_q <= '0;
      mode_q  <= MODE_IDLE;
    end else begin
      if (div_wr)  div_q  <= div_wdata;
      if (ctrl_wr) ctrl_q <= ctrl_wdata;
      count_q <= cnt_d;
      mode_q  <= mode_d;
    end
  end
endmodule

// File: rtl/cdtimer_irq.sv
module cdtimer_irq #(
  parameter int NUM_CH = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mask_wr,
  input  logic              ack_wr,
  input  logic [NUM_CH-1:0] wdata,
  input  logic [NUM_CH-1:0] expire,
  output logic [NUM_CH-1:0] raw_q,
  output logic [NUM_CH-1:0] mask_q
);
  logic [NUM_CH-1:0] clr;
  logic [NUM_CH-1:0] raw_d;

  assign clr   = ack_wr ? wdata : '0;
  // set after clear: a same-cycle expiry keeps its bit
  assign raw_d = (raw_q & ~clr) | expire;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raw_q  <= '0;
      mask_q <= '0;
    end else begin
      raw_q <= raw_d;
      if (mask_wr) mask_q <= wdata;
    end
  end
endmodule

// File: rtl/dual_countdown_timer.sv
module dual_countdown_timer
  import cdtimer_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 32,
  parameter int RATE_W = 3,
  parameter int NUM_CH = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq
);
  localparam int CTRL_W = RATE_W + 2;
  localparam int NTAP   = 2 ** RATE_W;
  localparam logic [ADDR_W-1:0] A_TIME = ADDR_W'(OFS_TIME);
  localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(OFS_MASK);
  localparam logic [ADDR_W-1:0] A_ACK  = ADDR_W'(OFS_ACK);
  localparam logic [ADDR_W-1:0] A_RAW  = ADDR_W'(OFS_RAW);
  localparam logic [ADDR_W-1:0] A_MSKD = ADDR_W'(OFS_MSKD);

  logic [NTAP-1:0]                tick_vec;
  logic [NUM_CH-1:0]              ch_run, ch_exp, div_wr, ctrl_wr;
  logic [NUM_CH-1:0][CNT_W-1:0]   ch_cnt, ch_div;
  logic [NUM_CH-1:0][CTRL_W-1:0]  ch_ctrl;
  logic [NUM_CH-1:0]              raw_q, mask_q, masked;
  logic [DATA_W-1:0]              time_q;

  cdtimer_prescale #(.RATE_W(RATE_W)) u_pre (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick_o (tick_vec)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    localparam logic [ADDR_W-1:0] A_DIV  = ADDR_W'(c * CH_STRIDE + OFS_DIV);
    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(c * CH_STRIDE + OFS_CTRL);

    assign div_wr[c]  = bus_wr && (bus_addr == A_DIV);
    assign ctrl_wr[c] = bus_wr && (bus_addr == A_CTRL);

    cdtimer_channel #(.CNT_W(CNT_W), .RATE_W(RATE_W)) u_ch (
      .clk        (clk),
      .rst_n      (rst_n),
      .div_wr     (div_wr[c]),
      .ctrl_wr    (ctrl_wr[c]),
      .div_wdata  (bus_wdata[CNT_W-1:0]),
      .ctrl_wdata (bus_wdata[CTRL_W-1:0]),
      .tick_vec   (tick_vec),
      .div_q      (ch_div[c]),
      .ctrl_q     (ch_ctrl[c]),
      .count_q    (ch_cnt[c]),
      .running    (ch_run[c]),
      .expire     (ch_exp[c])
    );
  end

  cdtimer_irq #(.NUM_CH(NUM_CH)) u_irq (
    .clk     (clk),
    .rst_n   (rst_n),
    .mask_wr (bus_wr && (bus_addr == A_MASK)),
    .ack_wr  (bus_wr && (bus_addr == A_ACK)),
    .wdata   (bus_wdata[NUM_CH-1:0]),
    .expire  (ch_exp),
    .raw_q   (raw_q),
    .mask_q  (mask_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) time_q <= '0;
    else        time_q <= time_q + 1'b1;
  end

  assign masked = raw_q & mask_q;
  assign irq    = masked[0];

  // Combinational read mux, side-effect free
  always_comb begin
    bus_rdata = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      if (bus_addr == ADDR_W'(c * CH_STRIDE + OFS_DIV))  bus_rdata = DATA_W'(ch_div[c]);
      if (bus_addr == ADDR_W'(c * CH_STRIDE + OFS_DATA)) bus_rdata = DATA_W'(ch_cnt[c]);
      if (bus_addr == ADDR_W'(c * CH_STRIDE + OFS_CTRL)) bus_rdata = DATA_W'(ch_ctrl[c]);
    end
    if (bus_addr == A_TIME) bus_rdata = time_q;
    if (bus_addr == A_MASK) bus_rdata = DATA_W'(mask_q);
    if (bus_addr == A_RAW)  bus_rdata = DATA_W'(raw_q);
    if (bus_addr == A_MSKD) bus_rdata = DATA_W'(masked);
  end
endmodule

// File: rtl/dual_countdown_timer_chk.sv
module dual_countdown_timer_chk
  import cdtimer_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              wdata0,
  input logic              irq,
  input logic [DATA_W-1:0] time_q,
  input logic              raw0,
  input logic              exp0,
  input logic              run0,
  input logic [CNT_W-1:0]  cnt0
);
  logic ack_wr, mask_wr, ctrl0_wr;
  assign ack_wr   = bus_wr && (bus_addr == ADDR_W'(OFS_ACK));
  assign mask_wr  = bus_wr && (bus_addr == ADDR_W'(OFS_MASK));
  assign ctrl0_wr = bus_wr && (bus_addr == ADDR_W'(OFS_CTRL));

  // R6
  expiry_sets_raw_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exp0 |=> raw0);

  // R7
  ack_clears_raw_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_wr && wdata0 && !exp0) |=> !raw0);

  // R8
  mask_off_drops_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_wr && !wdata0) |=> !irq);

  // R4
  held_count_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run0 && !ctrl0_wr) |=> $stable(cnt0));

  // R9
  time_advances_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> (time_q == $past(time_q) + 1'b1));
endmodule

bind dual_countdown_timer dual_countdown_timer_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .bus_wr   (bus_wr),
  .bus_addr (bus_addr),
  .wdata0   (bus_wdata[0]),
  .irq      (irq),
  .time_q   (time_q),
  .raw0     (raw_q[0]),
  .exp0     (ch_exp[0]),
  .run0     (ch_run[0]),
  .cnt0     (ch_cnt[0])
);

// File: tb/tb_dual_countdown_timer.sv
module tb_dual_countdown_timer;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  b_addr = 8'h00;
  logic        b_wr = 1'b0;
  logic [31:0] b_wdata = '0;
  logic [31:0] b_rdata;
  logic        irq;

  int    compared = 0;
  int    mism = 0;
  bit    done = 1'b0;
  string phase = "R1 reset";

  // Behavioural reference state
  logic [31:0] m_div [2];
  logic [31:0] m_cnt [2];
  logic [31:0] m_ctrl[2];
  int          m_mode[2];   // 0 stopped, 1 one-shot, 2 periodic
  logic [31:0] m_time;
  logic [1:0]  m_mask, m_raw;
  int          m_pre;

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_countdown_timer dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(b_addr), .bus_wr(b_wr),
    .bus_wdata(b_wdata), .bus_rdata(b_rdata), .irq(irq)
  );

  task automatic model_reset();
    for (int c = 0; c < 2; c++) begin
      m_div[c] = 0; m_cnt[c] = 0; m_ctrl[c] = 0; m_mode[c] = 0;
    end
    m_time = 0; m_mask = 0; m_raw = 0; m_pre = 0;
  endtask

  initial model_reset();

  always @(posedge clk) begin
    if (!rst_n) begin
      model_reset();
    end else begin
      logic [1:0] ex;
      ex = 2'b00;
      for (int c = 0; c < 2; c++) begin
        int k, msk;
        bit tick;
        k    = (m_ctrl[c] >> 2) & 7;
        msk  = (1 << k) - 1;
        tick = ((m_pre & msk) == msk);
        if (b_wr && b_addr == 8'(16*c + 8)) begin
          case (b_wdata & 3)
            0: begin m_cnt[c] = m_div[c]; m_mode[c] = 1; end
            1: m_mode[c] = 0;
            2: m_mode[c] = 2;
            default: ;
          endcase
          m_ctrl[c] = b_wdata & 32'h1f;
        end else if (tick && m_mode[c] != 0) begin
          if (m_cnt[c] <= 1) begin
            ex[c] = 1'b1;
            if (m_mode[c] == 2) m_cnt[c] = m_div[c];
            else begin m_cnt[c] = 0; m_mode[c] = 0; end
          end else m_cnt[c] = m_cnt[c] - 1;
        end
        if (b_wr && b_addr == 8'(16*c)) m_div[c] = b_wdata;
      end
      if (b_wr && b_addr == 8'h40) m_mask = b_wdata[1:0];
      if (b_wr && b_addr == 8'h44) m_raw = m_raw & ~b_wdata[1:0];
      m_raw  = m_raw | ex;
      m_time = m_time + 1;
      m_pre  = m_pre + 1;
    end
  end

  function automatic logic [31:0] model_rd(logic [7:0] a);
    case (a)
      8'h00: return m_div[0];
      8'h04: return m_cnt[0];
      8'h08: return m_ctrl[0];
      8'h10: return m_div[1];
      8'h14: return m_cnt[1];
      8'h18: return m_ctrl[1];
      8'h30: return m_time;
      8'h40: return {30'd0, m_mask};
      8'h48: return {30'd0, m_raw};
      8'h4C: return {30'd0, m_raw & m_mask};
      default: return 32'd0;
    endcase
  endfunction

  always @(negedge clk) begin
    if (rst_n && !done) begin
      compared++;
      if (b_rdata !== model_rd(b_addr)) begin
        mism++;
        $display("FAIL %s: rdata@%h actual=%h expected=%h", phase, b_addr, b_rdata, model_rd(b_addr));
      end
      compared++;
      if (irq !== (m_raw[0] & m_mask[0])) begin
        mism++;
        $display("FAIL %s (R8 irq): actual=%b expected=%b", phase, irq, m_raw[0] & m_mask[0]);
      end
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    b_addr = a; b_wr = 1'b1; b_wdata = d;
    @(posedge clk); #1;
    b_wr = 1'b0;
  endtask

  task automatic look(input logic [7:0] a, input int n);
    @(posedge clk); #1;
    b_addr = a;
    repeat (n) @(posedge clk);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1 reset values observed while reset is held
    compared++;
    if (b_rdata !== 32'd0 || irq !== 1'b0) begin
      mism++;
      $display("FAIL R1 reset: rdata=%h irq=%b expected 0/0", b_rdata, irq);
    end
    rst_n = 1'b1;
    for (int a = 0; a < 8'h50; a += 4) look(8'(a), 1);

    phase = "R10 map";
    wr(8'h00, 32'd5); look(8'h00, 2);
    wr(8'h04, 32'h77); look(8'h04, 2);
    wr(8'h48, 32'h3); look(8'h48, 2);
    wr(8'h4C, 32'h3); look(8'h4C, 2);
    look(8'h20, 2); look(8'h50, 2); look(8'h44, 2);

    phase = "R2 one-shot / R11";
    wr(8'h08, 32'hFFFF_FFE0); look(8'h08, 1); look(8'h04, 10); look(8'h48, 2);

    phase = "R8 mask";
    wr(8'h40, 32'h1); look(8'h4C, 3);
    phase = "R7 ack";
    wr(8'h44, 32'h1); look(8'h48, 2);
    wr(8'h40, 32'h0); look(8'h4C, 2);
    wr(8'h40, 32'h3);

    phase = "R3 periodic";
    wr(8'h00, 32'd3); wr(8'h08, 32'd2); look(8'h04, 12); look(8'h48, 2);

    phase = "R4 hold/reserved";
    wr(8'h08, 32'd1); look(8'h04, 6);
    wr(8'h08, 32'd3); look(8'h04, 6);
    wr(8'h08, 32'd2); look(8'h04, 3);
    wr(8'h08, 32'd3); look(8'h04, 6);
    wr(8'h08, 32'd1); look(8'h04, 2);

    phase = "R5 rate";
    wr(8'h10, 32'd2); wr(8'h18, 32'd0 | (3 << 2)); look(8'h14, 40);
    wr(8'h18, 32'd2 | (3 << 2)); look(8'h14, 30); look(8'h48, 2);
    wr(8'h18, 32'd1 | (1 << 2)); look(8'h18, 2);

    phase = "R6 R7 collide";
    wr(8'h44, 32'h3);
    wr(8'h00, 32'd1); wr(8'h08, 32'd2);
    for (int i = 0; i < 6; i++) begin wr(8'h44, 32'h1); look(8'h48, 1); end
    wr(8'h08, 32'd1); wr(8'h44, 32'h3); look(8'h48, 2); look(8'h4C, 2);

    phase = "R9 time";
    look(8'h30, 20);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mism);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      mism++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mism);
      $finish;
    end
  end
endmodule